// File: doc/BRIEF.md
# Per-Channel Event Store with Roll Mode

This block keeps a small event buffer for every input channel of a multi-channel front end and runs the chip-level acquisition handshake with an outside controller. While the acquisition window is open, a hit strobe on a channel stores that channel's 16-bit event word in the channel's next slot. Each channel keeps its own count and write pointer, independent of all the others.

A mode input selects between two fill policies. In stop mode a channel takes events until its eight slots are full. The first full channel closes the window for every channel. In roll mode the slots form a ring: every hit is stored, the oldest entry is overwritten, and the seven most recent events are kept. A busy output tells the controller that conversion is running. Busy rises after the acquisition strobe falls, or when a channel fills in stop mode. It falls when a fixed conversion time has passed, or at once when the controller asserts a timeout.

When the controller requests readout, the block shifts out a single serial stream. Channels that hold no events are skipped. Each channel that holds events sends a header word and then its events, newest first. Every 16-bit word is followed by an even parity bit. At the end of readout all channels are emptied and the block returns to acquisition.

Top module: `evs_top`

## Requirements
- R1: A channel never holds more than DEPTH (8) events.
- R2: In stop mode (`roll_mode`=0), a hit is stored only while no channel holds 8 events. The clock edge after a channel reaches 8 events, `busy` goes high without any falling edge of `acq_start`.
- R3: In roll mode (`roll_mode`=1), every accepted hit is stored. Only the 7 most recent events of a channel are kept. A channel filling up never raises `busy`.
- R4: `busy` is low after reset. One edge after `acq_start` is sampled falling during acquisition, `busy` goes high. It then stays high for exactly CONV_CYCLES (8) cycles.
- R5: `timeout` sampled high while `busy` is high makes `busy` low from the next cycle.
- R6: A hit is ignored when `acq_start` is low, and it is ignored outside the acquisition phase (during conversion, hold or readout).
- R7: Readout visits channels in ascending index order and skips channels with no events. An occupied channel sends a header word first: bits 15:8 hold the channel index, bits 7:4 are zero, and bits 3:0 hold the event count. It then sends its events newest first.
- R8: Every word is sent MSB first over 16 cycles, then one even parity bit, so each 17-bit group has an even number of ones. `sout_vld` is high for exactly these bits, with no gaps. `rd_done` pulses for one cycle after the last bit. All channels are then empty.
- R9: A pulse on `chn_clear[i]` empties channel i only. It has no effect during readout.
- R10: A readout with every channel empty sends no valid bits and still pulses `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| roll_mode | input | 1 | 0 = stop when full, 1 = ring keeping the latest 7 |
| acq_start | input | 1 | Acquisition window; its falling edge starts conversion |
| timeout | input | 1 | Forces busy low during conversion |
| hit | input | NCH | Per-channel hit strobes |
| evt_data | input | NCH*16 | Event word per channel, channel i in bits 16i+15:16i |
| chn_clear | input | NCH | Per-channel clear |
| rd_start | input | 1 | Starts readout once conversion has ended |
| busy | output | 1 | Conversion in progress |
| sout | output | 1 | Serial data |
| sout_vld | output | 1 | Marks a valid bit on sout |
| rd_done | output | 1 | One-cycle pulse after the last readout bit |

## Verification
The assertions assume that `roll_mode` does not change while a channel holds events. They also assume that `rd_start` arrives only after busy has fallen and that `acq_start` rises only after the previous readout has completed. The stimulus changes the mode only between full acquire-convert-read rounds, which always start from empty channels. It issues a readout only after it has watched busy fall, and it waits one cycle after `rd_done` before opening a new window. Hits during conversion and with the window closed are sent on purpose, so that the rejection logic is exercised.

// File: rtl/evs_pkg.sv
package evs_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        PH_ACQ  = 2'd0,
        PH_CONV = 2'd1,
        PH_HOLD = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    typedef struct packed {
        logic [7:0] chan;
        logic [3:0] rsvd;
        logic [3:0] count;
    } hdr_t;

    function automatic logic even_par(input logic [WORD_W-1:0] w);
        return ^w;
    endfunction

    function automatic logic [WORD_W:0] frame_of(input logic [WORD_W-1:0] w);
        return {w, even_par(w)};
    endfunction

endpackage

// File: rtl/evs_chan.sv
module evs_chan
    import evs_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              roll,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              clr,
    input  logic [PW-1:0]     rd_slot,
    output logic [WORD_W-1:0] rd_data,
    output logic [CW-1:0]     cnt,
    output logic [PW-1:0]     ptr,
    output logic              full
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic              store;

    assign full    = (cnt == CW'(DEPTH));
    assign store   = wr_en && !clr && (roll || !full);
    assign rd_data = mem[rd_slot];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ptr <= '0;
        end else if (store) begin
            ptr <= ptr + 1'b1;
            if (roll)
                cnt <= (cnt >= CW'(DEPTH - 1)) ? CW'(DEPTH - 1) : cnt + 1'b1;
            else
                cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (store)
            mem[ptr] <= wr_data;
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH)); // R1
    AST_ROLL_KEEP: assert property (@(posedge clk) disable iff (rst)
        (roll && wr_en && !clr) |=> (cnt <= CW'(DEPTH - 1))); // R3
    AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!roll && full && !clr) |=> full); // R2
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R9

endmodule

// File: rtl/evs_ctrl.sv
module evs_ctrl
    import evs_pkg::*;
#(
    parameter int CONV_CYCLES = 8,
    localparam int CCW = $clog2(CONV_CYCLES + 1)
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   acq_start,
    input  logic   roll_mode,
    input  logic   any_full,
    input  logic   timeout,
    input  logic   rd_start,
    input  logic   rd_done,
    output phase_e phase,
    output logic   busy,
    output logic   accept,
    output logic   ser_start,
    output logic   clear_all
);

    logic           acq_q;
    logic [CCW-1:0] conv_cnt;
    logic           acq_fall;
    logic           stop_full;

    assign acq_fall  = acq_q && !acq_start;
    assign stop_full = !roll_mode && any_full;
    assign busy      = (phase == PH_CONV);
    assign accept    = (phase == PH_ACQ) && acq_start && !stop_full;
    assign ser_start = (phase == PH_HOLD) && rd_start;
    assign clear_all = (phase == PH_READ) && rd_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_ACQ;
            acq_q    <= 1'b0;
            conv_cnt <= '0;
        end else begin
            acq_q <= acq_start;
            case (phase)
                PH_ACQ: begin
                    if (acq_fall || stop_full) begin
                        phase    <= PH_CONV;
                        conv_cnt <= '0;
                    end
                end
                PH_CONV: begin
                    if (timeout || conv_cnt == CCW'(CONV_CYCLES - 1))
                        phase <= PH_HOLD;
                    else
                        conv_cnt <= conv_cnt + 1'b1;
                end
                PH_HOLD: begin
                    if (rd_start)
                        phase <= PH_READ;
                end
                default: begin
                    if (rd_done)
                        phase <= PH_ACQ;
                end
            endcase
        end
    end

    AST_BUSY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACQ && acq_q && !acq_start) |=> busy); // R4
    AST_FULL_STOPS: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ACQ && !roll_mode && any_full) |=> busy); // R2
    AST_TIMEOUT_DROP: assert property (@(posedge clk) disable iff (rst)
        (busy && timeout) |=> !busy); // R5

endmodule

// File: rtl/evs_serial.sv
module evs_serial
    import evs_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DEPTH = 8,
    localparam int CW  = $clog2(DEPTH + 1),
    localparam int PW  = $clog2(DEPTH),
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [NCH-1:0][CW-1:0]  cnt,
    input  logic [NCH-1:0][PW-1:0]  ptr,
    input  logic [WORD_W-1:0]       rd_word,
    output logic [CHW-1:0]          rd_ch,
    output logic [PW-1:0]           rd_slot,
    output logic                    sout,
    output logic                    sout_vld,
    output logic                    done
);

    logic           act_q;
    logic [CHW-1:0] ch_q;
    logic [CW-1:0]  widx_q;
    logic [4:0]     bidx_q;
    logic           done_q;

    logic [CHW-1:0] first_ch, nxt_ch;
    logic           first_ok, nxt_ok;
    hdr_t           hdr;
    logic [WORD_W-1:0] word;
    logic [WORD_W:0]   frame;

    always_comb begin
        first_ch = '0;
        first_ok = 1'b0;
        nxt_ch   = '0;
        nxt_ok   = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (cnt[i] != '0) begin
                first_ch = CHW'(i);
                first_ok = 1'b1;
                if (i > int'(ch_q)) begin
                    nxt_ch = CHW'(i);
                    nxt_ok = 1'b1;
                end
            end
        end
    end

    always_comb begin
        hdr.chan  = 8'(ch_q);
        hdr.rsvd  = 4'd0;
        hdr.count = 4'(cnt[ch_q]);
        word      = (widx_q == '0) ? WORD_W'(hdr) : rd_word;
        frame     = frame_of(word);
    end

    assign rd_ch    = ch_q;
    assign rd_slot  = PW'(ptr[ch_q]) - PW'(widx_q);
    assign sout     = act_q && frame[5'd16 - bidx_q];
    assign sout_vld = act_q;
    assign done     = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            ch_q   <= '0;
            widx_q <= '0;
            bidx_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!act_q) begin
                if (start) begin
                    if (first_ok) begin
                        act_q  <= 1'b1;
                        ch_q   <= first_ch;
                        widx_q <= '0;
                        bidx_q <= '0;
                    end else begin
                        done_q <= 1'b1;
                    end
                end
            end else if (bidx_q == 5'd16) begin
                bidx_q <= '0;
                if (widx_q == cnt[ch_q]) begin
                    if (nxt_ok) begin
                        ch_q   <= nxt_ch;
                        widx_q <= '0;
                    end else begin
                        act_q  <= 1'b0;
                        done_q <= 1'b1;
                    end
                end else begin
                    widx_q <= widx_q + 1'b1;
                end
            end else begin
                bidx_q <= bidx_q + 1'b1;
            end
        end
    end

    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        act_q |-> (widx_q <= cnt[ch_q])); // R7
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !act_q); // R10

endmodule

// File: rtl/evs_top.sv
module evs_top
    import evs_pkg::*;
#(
    parameter int NCH         = 4,
    parameter int DEPTH       = 8,
    parameter int CONV_CYCLES = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  roll_mode,
    input  logic                  acq_start,
    input  logic                  timeout,
    input  logic [NCH-1:0]        hit,
    input  logic [NCH*WORD_W-1:0] evt_data,
    input  logic [NCH-1:0]        chn_clear,
    input  logic                  rd_start,
    output logic                  busy,
    output logic                  sout,
    output logic                  sout_vld,
    output logic                  rd_done
);

    localparam int CW  = $clog2(DEPTH + 1);
    localparam int PW  = $clog2(DEPTH);
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    phase_e                      phase;
    logic                        accept, ser_start, clear_all;
    logic [NCH-1:0][CW-1:0]      cnt_all;
    logic [NCH-1:0][PW-1:0]      ptr_all;
    logic [NCH-1:0][WORD_W-1:0]  dout_all;
    logic [NCH-1:0]              full_all;
    logic [CHW-1:0]              rd_ch;
    logic [PW-1:0]               rd_slot;
    logic [WORD_W-1:0]           rd_word;

    assign rd_word = dout_all[rd_ch];

    evs_ctrl #(.CONV_CYCLES(CONV_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .acq_start (acq_start),
        .roll_mode (roll_mode),
        .any_full  (|full_all),
        .timeout   (timeout),
        .rd_start  (rd_start),
        .rd_done   (rd_done),
        .phase     (phase),
        .busy      (busy),
        .accept    (accept),
        .ser_start (ser_start),
        .clear_all (clear_all)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        evs_chan #(.DEPTH(DEPTH)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .roll    (roll_mode),
            .wr_en   (accept && hit[i]),
            .wr_data (evt_data[i*WORD_W +: WORD_W]),
            .clr     (clear_all || (chn_clear[i] && phase != PH_READ)),
            .rd_slot (rd_slot),
            .rd_data (dout_all[i]),
            .cnt     (cnt_all[i]),
            .ptr     (ptr_all[i]),
            .full    (full_all[i])
        );
    end

    evs_serial #(.NCH(NCH), .DEPTH(DEPTH)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (ser_start),
        .cnt      (cnt_all),
        .ptr      (ptr_all),
        .rd_word  (rd_word),
        .rd_ch    (rd_ch),
        .rd_slot  (rd_slot),
        .sout     (sout),
        .sout_vld (sout_vld),
        .done     (rd_done)
    );

    AST_VLD_IN_READ: assert property (@(posedge clk) disable iff (rst)
        sout_vld |-> (phase == PH_READ)); // R8
    AST_READ_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READ) |-> !busy); // R4

endmodule

// File: tb/evs_top_tb.sv
`timescale 1ns/1ps
module evs_top_tb;

    localparam int NCH = 4;
    localparam int DEPTH = 8;
    localparam int CONV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic roll_mode = 1'b0, acq_start = 1'b0, timeout = 1'b0, rd_start = 1'b0;
    logic [NCH-1:0] hit = '0, chn_clear = '0;
    logic [NCH*16-1:0] evt_data = '0;
    logic busy, sout, sout_vld, rd_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] hist [NCH][64];
    int nacc [NCH];
    logic exp_bits [2048];
    int exp_len;
    logic act_bits [2048];
    int act_len;

    always #2.5 clk = ~clk;

    evs_top #(.NCH(NCH), .DEPTH(DEPTH), .CONV_CYCLES(CONV)) u_dut (
        .clk(clk), .rst(rst), .roll_mode(roll_mode), .acq_start(acq_start),
        .timeout(timeout), .hit(hit), .evt_data(evt_data), .chn_clear(chn_clear),
        .rd_start(rd_start), .busy(busy), .sout(sout), .sout_vld(sout_vld),
        .rd_done(rd_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] dval(input int ch, input int k);
        return {4'(ch), 12'(k * 37 + 5)};
    endfunction

    function automatic bit any_full_model();
        for (int c = 0; c < NCH; c++) if (nacc[c] >= DEPTH) return 1;
        return 0;
    endfunction

    // drive one hit; live=1 means the window is open and acquisition phase
    task automatic hit_one(input int ch, input int k, input bit live);
        hit[ch] = 1'b1;
        evt_data[ch*16 +: 16] = dval(ch, k);
        if (live) begin
            if (roll_mode || !any_full_model()) begin
                hist[ch][nacc[ch]] = dval(ch, k);
                nacc[ch]++;
            end
        end
        @(negedge clk);
        hit[ch] = 1'b0;
    endtask

    task automatic clear_model();
        for (int c = 0; c < NCH; c++) nacc[c] = 0;
    endtask

    task automatic push_word(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) begin
            exp_bits[exp_len] = w[b];
            exp_len++;
        end
        exp_bits[exp_len] = ^w;
        exp_len++;
    endtask

    task automatic build_expected();
        exp_len = 0;
        for (int c = 0; c < NCH; c++) begin
            int kept;
            kept = roll_mode ? ((nacc[c] > DEPTH - 1) ? DEPTH - 1 : nacc[c]) : nacc[c];
            if (kept > 0) begin
                push_word({8'(c), 4'd0, 4'(kept)});
                for (int k = 0; k < kept; k++) push_word(hist[c][nacc[c] - 1 - k]);
            end
        end
    endtask

    // close the window and wait for conversion to end; returns busy length
    task automatic end_acq(output int blen);
        acq_start = 1'b0;
        @(negedge clk);
        blen = 0;
        while (busy && blen < 100) begin
            blen++;
            @(negedge clk);
        end
    endtask

    task automatic read_check(input string req);
        int guard;
        bit seen_done;
        int mism;
        build_expected();
        act_len = 0;
        rd_start = 1'b1;
        @(negedge clk);
        rd_start = 1'b0;
        guard = 0;
        seen_done = 0;
        while (!seen_done && guard < 2000) begin
            if (sout_vld) begin
                act_bits[act_len] = sout;
                act_len++;
            end
            if (rd_done) seen_done = 1;
            else @(negedge clk);
            guard++;
        end
        @(negedge clk);
        chk(seen_done, {req, " R8 done pulse"}, int'(seen_done), 1);
        chk(act_len == exp_len, {req, " R7 bit count"}, act_len, exp_len);
        mism = -1;
        for (int i = 0; i < exp_len && i < act_len; i++)
            if (mism < 0 && act_bits[i] !== exp_bits[i]) mism = i;
        chk(mism < 0, {req, " R8 first mismatching bit index"}, mism, -1);
        clear_model();
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int blen;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4 reset state
        chk(busy == 1'b0, "R4 busy after reset", int'(busy), 0);
        chk(sout_vld == 1'b0, "R8 no output after reset", int'(sout_vld), 0);

        // stop mode, two channels
        roll_mode = 1'b0;
        acq_start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) hit_one(0, k, 1);
        for (int k = 0; k < 5; k++) hit_one(2, k + 10, 1);
        chk(busy == 1'b0, "R4 busy low during window", int'(busy), 0);
        end_acq(blen);
        chk(blen == CONV, "R4 busy length", blen, CONV);
        read_check("R7 two channels");

        // R6 hits with window closed and during conversion are ignored
        hit_one(1, 1, 0);
        hit_one(1, 2, 0);
        acq_start = 1'b1;
        @(negedge clk);
        hit_one(3, 7, 1);
        acq_start = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R4 busy after fall", int'(busy), 1);
        hit_one(0, 9, 0);
        blen = 0;
        while (busy && blen < 100) begin blen++; @(negedge clk); end
        read_check("R6 ignored hits");

        // R2 stop on full: another channel's hit right after the eighth is dropped
        acq_start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < DEPTH; k++) hit_one(1, k, 1);
        chk(busy == 1'b0, "R2 busy one cycle after eighth", int'(busy), 0);
        hit_one(0, 3, 1);
        chk(busy == 1'b1, "R2 busy from full", int'(busy), 1);
        hit_one(1, 40, 0);
        end_acq(blen);
        read_check("R2 full channel");

        // R3 roll mode keeps the last seven
        roll_mode = 1'b1;
        acq_start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 12; k++) hit_one(2, k, 1);
        for (int k = 0; k < 3; k++) hit_one(0, k + 20, 1);
        chk(busy == 1'b0, "R3 no busy from full in roll", int'(busy), 0);
        end_acq(blen);
        chk(blen == CONV, "R3 busy length in roll", blen, CONV);
        read_check("R3 roll");
        roll_mode = 1'b0;

        // R5 timeout
        acq_start = 1'b1;
        @(negedge clk);
        hit_one(3, 2, 1);
        acq_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(busy == 1'b1, "R5 busy before timeout", int'(busy), 1);
        timeout = 1'b1;
        @(negedge clk);
        timeout = 1'b0;
        chk(busy == 1'b0, "R5 busy dropped by timeout", int'(busy), 0);
        read_check("R5 after timeout");

        // R9 per-channel clear
        acq_start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) hit_one(0, k, 1);
        for (int k = 0; k < 2; k++) hit_one(1, k + 4, 1);
        chn_clear[0] = 1'b1;
        nacc[0] = 0;
        @(negedge clk);
        chn_clear[0] = 1'b0;
        hit_one(0, 30, 1);
        end_acq(blen);
        read_check("R9 clear");

        // R10 empty readout
        acq_start = 1'b1;
        @(negedge clk);
        end_acq(blen);
        read_check("R10 empty");
        chk(act_len == 0, "R10 no bits", act_len, 0);

        // sweep: both modes, 0..11 hits on a rotating channel
        for (int m = 0; m < 2; m++) begin
            for (int n = 0; n < 12; n++) begin
                roll_mode = 1'(m);
                acq_start = 1'b1;
                @(negedge clk);
                for (int k = 0; k < n; k++) hit_one(n % NCH, k + n * 3, 1);
                if (m == 1 || n < DEPTH) begin
                    end_acq(blen);
                    chk(blen == CONV, "R4 sweep busy length", blen, CONV);
                end else begin
                    end_acq(blen);
                end
                read_check(m ? "R3 sweep" : "R2 sweep");
            end
        end
        roll_mode = 1'b0;

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule